// File: doc/BRIEF.md
# Software-Managed Translation Lookaside Buffer

This block translates the virtual address of one memory access per cycle into a physical address. It searches a fully associative table of page translations that privileged software loads. Each table entry holds a virtual page number, a physical frame number, an address-space identifier and four flags: global, valid, writable and no-cache. Pages are 4 KB. The low 12 address bits go through unchanged, and the frame number replaces the page number.

Each request carries an address, a read/write flag, a user-mode flag and the current address-space identifier. One cycle later the block reports exactly one of four results: hit, address error, miss or modification fault. On a hit it also returns the physical address and an uncached flag. When the block reports a fault, software services it, writes an entry through the load port and retries the access. A flush input clears every entry on a context switch.

Top module: `tlb_xlate`

## Requirements
- R1: After reset the table holds no valid entries and every response output (`rsp_valid`, the four result flags, `rsp_uncached`) is 0.
- R2: The result of a request sampled at a clock edge appears on the outputs after that same edge. On a hit, `rsp_paddr` is the entry's frame number concatenated with the request's low 12 address bits.
- R3: A user-mode request whose address has bit 31 set produces `rsp_addr_err`, whatever the table holds. A kernel-mode request with bit 31 set is looked up in the table like any other address.
- R4: If no entry's page number equals address bits 31..12, the request produces `rsp_miss`.
- R5: An entry with a matching page number is used only if its identifier equals `req_asid` or its global flag is 1. Otherwise it is treated as absent, which gives a miss.
- R6: If the selected entry has its valid flag at 0, the request produces `rsp_miss`.
- R7: A write that selects a valid entry whose writable flag is 0 produces `rsp_mod`. A read of the same entry hits.
- R8: A hit on an entry whose no-cache flag is 1 drives `rsp_uncached` to 1. `rsp_uncached` is 0 on every other response.
- R9: A flush clears the valid flag of every entry, so later requests miss. If a flush and an entry write occur in the same cycle, the flush wins and the written entry is not valid.
- R10: Each request sets `rsp_valid` and exactly one of `rsp_hit`, `rsp_addr_err`, `rsp_miss` and `rsp_mod`. With no request, all of them are 0. The priority is address error, then miss, then modification fault.
- R11: When several entries pass the page-number and identifier test, the one with the lowest index is used.
- R12: An entry written at a clock edge affects requests from the next edge on. A request sampled at the same edge sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| req_asid | input | ASID_W | Current address-space identifier |
| wr_en | input | 1 | Load an entry |
| wr_index | input | clog2(ENTRIES) | Entry slot to load |
| wr_vpn | input | 20 | Virtual page number |
| wr_pfn | input | 20 | Physical frame number |
| wr_asid | input | ASID_W | Entry identifier |
| wr_global | input | 1 | Entry matches any identifier |
| wr_valid | input | 1 | Entry valid flag |
| wr_writable | input | 1 | Writes permitted |
| wr_nocache | input | 1 | Accesses bypass caches |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Physical address (hit only, else 0) |
| rsp_uncached | output | 1 | Hit page is uncached |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_addr_err | output | 1 | User access to kernel half |
| rsp_miss | output | 1 | No usable entry |
| rsp_mod | output | 1 | Write to read-only page |

## Verification
The bench builds the block with ENTRIES=8 and ASID_W=6, so it can reach both the first and the last slot with a few writes. The same setting lets it place duplicate matches at chosen indices to check that the lowest index wins. Directed scenarios cover each step of the fault priority chain, including a user access to the kernel half that would otherwise hit. They also cover the ordering between a write and a request in the same cycle, and a flush in the same cycle as a write.

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int ENTRIES   = 64,
  parameter int ASID_W    = 8,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int VPN_W = VA_W - PAGE_BITS,
  localparam int PFN_W = PA_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  input  logic              req_user,
  input  logic [ASID_W-1:0] req_asid,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic              wr_valid,
  input  logic              wr_writable,
  input  logic              wr_nocache,
  input  logic              flush,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_uncached,
  output logic              rsp_hit,
  output logic              rsp_addr_err,
  output logic              rsp_miss,
  output logic              rsp_mod
);

  logic [VPN_W-1:0]  vpn_q  [ENTRIES];
  logic [PFN_W-1:0]  pfn_q  [ENTRIES];
  logic [ASID_W-1:0] asid_q [ENTRIES];
  logic [ENTRIES-1:0] glb_q, vld_q, wen_q, nc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_index] <= wr_valid;
    end
    if (wr_en) begin
      vpn_q[wr_index]  <= wr_vpn;
      pfn_q[wr_index]  <= wr_pfn;
      asid_q[wr_index] <= wr_asid;
      glb_q[wr_index]  <= wr_global;
      wen_q[wr_index]  <= wr_writable;
      nc_q[wr_index]   <= wr_nocache;
    end
  end

  wire [VPN_W-1:0] req_vpn = req_vaddr[VA_W-1:PAGE_BITS];
  logic [ENTRIES-1:0] tag_hit;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign tag_hit[i] = (vpn_q[i] == req_vpn) && (glb_q[i] || asid_q[i] == req_asid);
  end

  logic             found;
  logic [IDX_W-1:0] sel;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (tag_hit[i]) begin
        found = 1'b1;
        sel   = IDX_W'(i);
      end
    end
  end

  wire kern_err = req_user && req_vaddr[VA_W-1];
  wire no_xlate = !found || !vld_q[sel];
  wire ro_fault = req_write && !wen_q[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_paddr    <= '0;
      rsp_uncached <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_addr_err <= 1'b0;
      rsp_miss     <= 1'b0;
      rsp_mod      <= 1'b0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_addr_err <= req_valid && kern_err;
      rsp_miss     <= req_valid && !kern_err && no_xlate;
      rsp_mod      <= req_valid && !kern_err && !no_xlate && ro_fault;
      rsp_hit      <= req_valid && !kern_err && !no_xlate && !ro_fault;
      if (req_valid && !kern_err && !no_xlate && !ro_fault) begin
        rsp_paddr    <= {pfn_q[sel], req_vaddr[PAGE_BITS-1:0]};
        rsp_uncached <= nc_q[sel];
      end else begin
        rsp_paddr    <= '0;
        rsp_uncached <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [VA_W-1:0] req_vaddr,
  input logic            req_write,
  input logic            req_user,
  input logic            flush,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_uncached,
  input logic            rsp_hit,
  input logic            rsp_addr_err,
  input logic            rsp_miss,
  input logic            rsp_mod
);

  p_one_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_addr_err, rsp_miss, rsp_mod}) == 1);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_addr_err || rsp_miss || rsp_mod));

  p_kernel_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_user && req_vaddr[VA_W-1] |=> rsp_addr_err);

  p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_hit || rsp_paddr[PAGE_BITS-1:0] == $past(req_vaddr[PAGE_BITS-1:0])));

  p_uncached_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_uncached |-> rsp_hit);

  p_mod_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write |=> !rsp_mod);

  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush ##1 req_valid |=> !rsp_hit);

endmodule

bind tlb_xlate tlb_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .req_write(req_write), .req_user(req_user), .flush(flush),
  .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_uncached(rsp_uncached),
  .rsp_hit(rsp_hit), .rsp_addr_err(rsp_addr_err), .rsp_miss(rsp_miss), .rsp_mod(rsp_mod)
);

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;
  localparam int N = 8;
  localparam int AW = 6;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_user = 0;
  logic [31:0] req_vaddr = '0;
  logic [AW-1:0] req_asid = '0;
  logic wr_en = 0, wr_global = 0, wr_valid = 0, wr_writable = 0, wr_nocache = 0, flush = 0;
  logic [2:0] wr_index = '0;
  logic [19:0] wr_vpn = '0, wr_pfn = '0;
  logic [AW-1:0] wr_asid = '0;
  logic rsp_valid, rsp_uncached, rsp_hit, rsp_addr_err, rsp_miss, rsp_mod;
  logic [31:0] rsp_paddr;

  int checks = 0, failures = 0;
  localparam logic [3:0] HIT = 4'b1000, AE = 4'b0100, MISS = 4'b0010, MOD = 4'b0001, NONE = 4'b0000;

  tlb_xlate #(.ENTRIES(N), .ASID_W(AW)) i_tlb_xlate (.*);

  always #10 clk = ~clk;

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(string tag, logic [3:0] er, logic [31:0] epa, logic eu);
    logic [3:0] ar = {rsp_hit, rsp_addr_err, rsp_miss, rsp_mod};
    logic ev = (er != NONE);
    checks++;
    if (ar !== er || rsp_valid !== ev || rsp_uncached !== eu || (er == HIT && rsp_paddr !== epa)) begin
      failures++;
      $display("FAIL %s: res=%b valid=%b unc=%b pa=%h expected res=%b valid=%b unc=%b pa=%h",
               tag, ar, rsp_valid, rsp_uncached, rsp_paddr, er, ev, eu, epa);
    end
  endtask

  task automatic load(int idx, logic [19:0] vpn, logic [19:0] pfn, logic [AW-1:0] id,
                      logic g, logic v, logic w, logic nc);
    wr_en = 1; wr_index = 3'(idx); wr_vpn = vpn; wr_pfn = pfn; wr_asid = id;
    wr_global = g; wr_valid = v; wr_writable = w; wr_nocache = nc;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic lookup(string tag, logic [31:0] va, logic wr, logic usr, logic [AW-1:0] id,
                        logic [3:0] er, logic [31:0] epa, logic eu);
    req_valid = 1; req_vaddr = va; req_write = wr; req_user = usr; req_asid = id;
    @(negedge clk);
    req_valid = 0;
    chk(tag, er, epa, eu);
  endtask

  task automatic t_reset;
    chk("R1 reset outputs", NONE, 0, 0);
    lookup("R1 empty table kernel", 32'h0000_1234, 0, 0, 1, MISS, 0, 0);
    @(negedge clk);
    chk("R10 idle no result", NONE, 0, 0);
  endtask

  task automatic t_basic;
    load(0, 20'h00010, 20'hABCDE, 6'd3, 0, 1, 1, 0);
    load(7, 20'h00020, 20'h12345, 6'd3, 0, 1, 0, 1);
    lookup("R2 read hit idx0", 32'h0001_0ABC, 0, 1, 3, HIT, 32'hABCD_EABC, 0);
    lookup("R2 write hit writable", 32'h0001_0FFF, 1, 1, 3, HIT, 32'hABCD_EFFF, 0);
    lookup("R8 uncached hit idx7", 32'h0002_0004, 0, 1, 3, HIT, 32'h1234_5004, 1);
    lookup("R7 write to read-only", 32'h0002_0004, 1, 1, 3, MOD, 0, 0);
    lookup("R4 no page match", 32'h0003_0000, 0, 1, 3, MISS, 0, 0);
  endtask

  task automatic t_asid;
    lookup("R5 id mismatch", 32'h0001_0010, 0, 1, 4, MISS, 0, 0);
    load(1, 20'h00040, 20'h00777, 6'd9, 1, 1, 1, 0);
    lookup("R5 global any id", 32'h0004_0123, 0, 1, 2, HIT, 32'h0077_7123, 0);
  endtask

  task automatic t_valid;
    load(2, 20'h00050, 20'h00555, 6'd3, 0, 0, 1, 0);
    lookup("R6 invalid entry", 32'h0005_0000, 0, 1, 3, MISS, 0, 0);
    lookup("R6 invalid beats write fault", 32'h0005_0000, 1, 1, 3, MISS, 0, 0);
  endtask

  task automatic t_kernel;
    load(3, 20'h80001, 20'h00888, 6'd3, 1, 1, 0, 0);
    lookup("R3 user high addr", 32'h8000_1000, 0, 1, 3, AE, 0, 0);
    lookup("R3 user high write ro", 32'h8000_1000, 1, 1, 3, AE, 0, 0);
    lookup("R3 kernel high translated", 32'h8000_1020, 0, 0, 3, HIT, 32'h0088_8020, 0);
  endtask

  task automatic t_dup;
    load(6, 20'h00060, 20'h00BBB, 6'd3, 0, 1, 1, 0);
    load(4, 20'h00060, 20'h00AAA, 6'd3, 0, 1, 1, 0);
    lookup("R11 lowest index wins", 32'h0006_0001, 0, 1, 3, HIT, 32'h00AA_A001, 0);
  endtask

  task automatic t_order;
    wr_en = 1; wr_index = 3'd5; wr_vpn = 20'h00070; wr_pfn = 20'h00CCC; wr_asid = 6'd3;
    wr_global = 0; wr_valid = 1; wr_writable = 1; wr_nocache = 0;
    req_valid = 1; req_vaddr = 32'h0007_0002; req_write = 0; req_user = 1; req_asid = 3;
    @(negedge clk);
    wr_en = 0; req_valid = 0;
    chk("R12 same-cycle request sees old", MISS, 0, 0);
    lookup("R12 next cycle sees new", 32'h0007_0002, 0, 1, 3, HIT, 32'h00CC_C002, 0);
  endtask

  task automatic t_flush;
    flush = 1;
    wr_en = 1; wr_index = 3'd5; wr_vpn = 20'h00090; wr_pfn = 20'h00DDD; wr_asid = 6'd3;
    wr_global = 1; wr_valid = 1; wr_writable = 1; wr_nocache = 0;
    @(negedge clk);
    flush = 0; wr_en = 0;
    lookup("R9 flush clears entry", 32'h0001_0000, 0, 1, 3, MISS, 0, 0);
    lookup("R9 flush clears global", 32'h0004_0000, 0, 1, 3, MISS, 0, 0);
    lookup("R9 flush beats write", 32'h0009_0000, 0, 0, 3, MISS, 0, 0);
    load(0, 20'h00010, 20'h00EEE, 6'd3, 0, 1, 1, 0);
    lookup("R9 reload after flush", 32'h0001_0042, 0, 1, 3, HIT, 32'h00EE_E042, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_asid;
    t_valid;
    t_kernel;
    t_dup;
    t_order;
    t_flush;
    @(negedge clk);
    chk("R10 idle after run", NONE, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule